// File: doc/BRIEF.md
# Selectable Timer Clock Source Unit

This block decides when a free-running timer's prescaler may advance. A 3-bit selector picks the increment source. The choices are a divide-by-8 tick of the system clock gated by an external timer-clock pin, the rising edges of that pin, its falling edges, both of its edges, a free divide-by-8 tick, or no source at all. A separate angle-mode bit changes what the selector means. With angle mode on, the selector names which pin edge counts as a tooth event, and the block stops clocking the prescaler.

The external pin is asynchronous to the system clock. It passes through a two-stage synchronizer and then an edge detector, so each edge gives a pulse exactly one system clock wide. The selector and the mode bit are registered once before use. Two selector codes are reserved. In angle mode the two divide-by-8 codes are illegal. For these codes the block produces no pulses and sets a sticky error flag, which only reset clears. A small prescaler and timer counter are included so that the increment stream can be observed.

Top module: `tmr_clk_src`

## Requirements
- R1: With selector 000 and angle mode off, `inc_pulse` fires on a divide-by-8 tick only while the synchronized pin is high. A 16-cycle high window of the synchronized pin yields exactly 2 pulses, and a low pin yields none.
- R2: With selector 001 and angle mode off, each rising transition of `ext_pin` gives exactly one `inc_pulse`.
- R3: With selector 010 and angle mode off, each falling transition of `ext_pin` gives exactly one `inc_pulse`.
- R4: With selector 011 and angle mode off, every transition of `ext_pin` gives one `inc_pulse`.
- R5: With selector 100 and angle mode off, `inc_pulse` fires once in every 8 consecutive system-clock cycles, whatever the pin does, and never in two cycles in a row.
- R6: With selector 111 and angle mode off, `inc_pulse` and `tooth_pulse` stay low and `cfg_error` stays low.
- R7: Selectors 101 and 110 produce no pulses and set `cfg_error`. The flag stays high after the selector is changed to a legal value and clears only on reset.
- R8: With angle mode on, `inc_pulse` stays low. Selectors 001, 010 and 011 make `tooth_pulse` fire once per rising edge, once per falling edge, or once per edge of the pin respectively. Selector 111 gives no tooth pulses and no error.
- R9: With angle mode on, selectors 000 and 100 produce no pulses and set `cfg_error`.
- R10: Suppose a pin change is first sampled at rising clock edge P0. The resulting pulse is high from the edge after P0 until the next edge, which is exactly one cycle.
- R11: `presc_cnt` counts increment pulses modulo PRESC_DIV (default 4). `tmr_cnt` advances by one each time the prescaler wraps.
- R12: While `rst_n` is low, `inc_pulse`, `tooth_pulse`, `cfg_error`, `presc_cnt` and `tmr_cnt` are all zero. The registered selector resets to 001 (rising edge), and a new selector value takes effect one cycle after it is presented.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ext_pin | input | 1 | Asynchronous external timer-clock pin |
| src_sel | input | 3 | Increment source / tooth edge selector |
| angle_mode | input | 1 | 1 = tooth detection, 0 = normal timer clocking |
| inc_pulse | output | 1 | One-cycle prescaler increment |
| tooth_pulse | output | 1 | One-cycle tooth-detect event |
| cfg_error | output | 1 | Sticky illegal-selection flag |
| presc_cnt | output | PRESC_W | Observation prescaler value |
| tmr_cnt | output | CNT_W | Observation timer value |

## Verification
The assertions check several properties on every cycle:
- the error flag never drops outside reset;
- no increment appears in the off code or in angle mode;
- no tooth pulse appears in normal mode;
- the free divide-by-8 source never pulses in two adjacent cycles;
- the timer counter never advances by more than one.

Pulse counts per mode cannot be shown by any single-cycle property. The same holds for the two-tick yield of a gated high window, the synchronizer latency and the prescaler wrap point. These are shown by the bench scenarios, which drive pin waveforms and count the pulses over fixed windows.

// File: rtl/tcs_pkg.sv
// Package: shared selector encoding for the timer clock source unit.
// Assumes a 3-bit selector; code values are fixed by behaviour.
package tcs_pkg;
    typedef enum logic [2:0] {
        SRC_GATED_DIV8 = 3'b000,
        SRC_RISE       = 3'b001,
        SRC_FALL       = 3'b010,
        SRC_BOTH       = 3'b011,
        SRC_DIV8       = 3'b100,
        SRC_RSV_A      = 3'b101,
        SRC_RSV_B      = 3'b110,
        SRC_OFF        = 3'b111
    } src_sel_e;

    localparam logic [2:0] SEL_RESET = SRC_RISE;
endpackage

// File: rtl/tcs_pin_edge.sv
// Module: synchronizes an asynchronous pin and flags its edges.
// Assumes STAGES >= 2. Each edge of the synchronized level gives a
// single-cycle rise or fall strobe, one cycle after the last stage.
module tcs_pin_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_async,
    output logic pin_lvl,
    output logic rise,
    output logic fall
);
    logic [STAGES-1:0] chain_q;
    logic              prev_q;

    // Synchronizer shift chain plus one delayed copy for edge compare.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain_q <= '0;
            prev_q  <= 1'b0;
        end else begin
            chain_q <= {chain_q[STAGES-2:0], pin_async};
            prev_q  <= chain_q[STAGES-1];
        end
    end

    // Level and edge strobes from registered state.
    always_comb begin
        pin_lvl = chain_q[STAGES-1];
        rise    = chain_q[STAGES-1] & ~prev_q;
        fall    = ~chain_q[STAGES-1] & prev_q;
    end
endmodule

// File: rtl/tcs_div_tick.sv
// Module: free-running power-of-two divider emitting a wrap tick.
// Assumes DIV_LOG2 >= 1; tick is high one cycle in every 2**DIV_LOG2.
module tcs_div_tick #(
    parameter int DIV_LOG2 = 3
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    logic [DIV_LOG2-1:0] cnt_q;

    // Free-running counter, cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_q + 1'b1;
    end

    // Tick in the cycle the counter sits at its maximum (wraps next).
    always_comb tick = &cnt_q;
endmodule

// File: rtl/tcs_src_select.sv
// Module: combinational source decode for increment and tooth events.
// Assumes all inputs come from registers of the same clock domain.
module tcs_src_select
    import tcs_pkg::*;
(
    input  logic [2:0] sel,
    input  logic       angle,
    input  logic       pin_lvl,
    input  logic       rise,
    input  logic       fall,
    input  logic       tick,
    output logic       inc,
    output logic       tooth,
    output logic       illegal
);
    // Decode the selected source; angle mode redirects edges to tooth.
    always_comb begin
        inc     = 1'b0;
        tooth   = 1'b0;
        illegal = 1'b0;
        unique case (src_sel_e'(sel))
            SRC_GATED_DIV8: begin
                inc     = !angle && tick && pin_lvl;
                illegal = angle;
            end
            SRC_RISE: begin
                inc   = !angle && rise;
                tooth = angle && rise;
            end
            SRC_FALL: begin
                inc   = !angle && fall;
                tooth = angle && fall;
            end
            SRC_BOTH: begin
                inc   = !angle && (rise || fall);
                tooth = angle && (rise || fall);
            end
            SRC_DIV8: begin
                inc     = !angle && tick;
                illegal = angle;
            end
            SRC_RSV_A, SRC_RSV_B: illegal = 1'b1;
            SRC_OFF: ;
            default: illegal = 1'b1;
        endcase
    end
endmodule

// File: rtl/tcs_presc.sv
// Module: observation prescaler and timer counter.
// Assumes PRESC_DIV >= 2; the timer advances when the prescaler wraps.
module tcs_presc #(
    parameter int PRESC_DIV = 4,
    parameter int CNT_W     = 16,
    localparam int PRESC_W  = $clog2(PRESC_DIV)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               inc,
    output logic [PRESC_W-1:0] presc,
    output logic [CNT_W-1:0]   count
);
    localparam logic [PRESC_W-1:0] PRESC_MAX = PRESC_W'(PRESC_DIV - 1);

    // Count increments modulo PRESC_DIV and carry into the timer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            presc <= '0;
            count <= '0;
        end else if (inc) begin
            if (presc == PRESC_MAX) begin
                presc <= '0;
                count <= count + 1'b1;
            end else begin
                presc <= presc + 1'b1;
            end
        end
    end
endmodule

// File: rtl/tmr_clk_src.sv
// Module: selectable timer clock source unit (top).
// Registers the selector and mode, synchronizes the pin, generates
// divide-by-8 ticks, decodes the source and latches a sticky error.
// Assumes a synchronous active-low reset and one system clock.
module tmr_clk_src
    import tcs_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int DIV_LOG2    = 3,
    parameter int PRESC_DIV   = 4,
    parameter int CNT_W       = 16,
    localparam int PRESC_W    = $clog2(PRESC_DIV)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ext_pin,
    input  logic [2:0]         src_sel,
    input  logic               angle_mode,
    output logic               inc_pulse,
    output logic               tooth_pulse,
    output logic               cfg_error,
    output logic [PRESC_W-1:0] presc_cnt,
    output logic [CNT_W-1:0]   tmr_cnt
);
    logic [2:0] sel_q;
    logic       am_q;
    logic       err_q;
    logic       pin_lvl, pin_rise, pin_fall, div_tick;
    logic       inc_raw, tooth_raw, sel_illegal;

    // Register selector and mode; selector resets to rising edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q <= SEL_RESET;
            am_q  <= 1'b0;
        end else begin
            sel_q <= src_sel;
            am_q  <= angle_mode;
        end
    end

    tcs_pin_edge #(.STAGES(SYNC_STAGES)) u_pin (
        .clk      (clk),
        .rst_n    (rst_n),
        .pin_async(ext_pin),
        .pin_lvl  (pin_lvl),
        .rise     (pin_rise),
        .fall     (pin_fall)
    );

    tcs_div_tick #(.DIV_LOG2(DIV_LOG2)) u_div (
        .clk  (clk),
        .rst_n(rst_n),
        .tick (div_tick)
    );

    tcs_src_select u_sel (
        .sel    (sel_q),
        .angle  (am_q),
        .pin_lvl(pin_lvl),
        .rise   (pin_rise),
        .fall   (pin_fall),
        .tick   (div_tick),
        .inc    (inc_raw),
        .tooth  (tooth_raw),
        .illegal(sel_illegal)
    );

    // Sticky error: set by any illegal selection, cleared only by reset.
    always_ff @(posedge clk) begin
        if (!rst_n)           err_q <= 1'b0;
        else if (sel_illegal) err_q <= 1'b1;
    end

    // Drive the pulse outputs and the error flag.
    always_comb begin
        inc_pulse   = inc_raw;
        tooth_pulse = tooth_raw;
        cfg_error   = err_q;
    end

    tcs_presc #(.PRESC_DIV(PRESC_DIV), .CNT_W(CNT_W)) u_presc (
        .clk  (clk),
        .rst_n(rst_n),
        .inc  (inc_raw),
        .presc(presc_cnt),
        .count(tmr_cnt)
    );
endmodule

// File: rtl/tmr_clk_src_chk.sv
// Module: assertion checker bound into tmr_clk_src.
// Assumes it observes the registered selector and mode of the top.
module tmr_clk_src_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic [2:0]       sel_q,
    input logic             am_q,
    input logic             inc_pulse,
    input logic             tooth_pulse,
    input logic             cfg_error,
    input logic [CNT_W-1:0] tmr_cnt
);
    assert_err_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_error |=> cfg_error);

    assert_off_no_inc_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_q == 3'b111 && !am_q) |-> (!inc_pulse && !tooth_pulse));

    assert_angle_no_inc_R8: assert property (@(posedge clk) disable iff (!rst_n)
        am_q |-> !inc_pulse);

    assert_normal_no_tooth_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !am_q |-> !tooth_pulse);

    assert_div8_spacing_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_q == 3'b100 && !am_q && inc_pulse) |=> !inc_pulse);

    assert_tmr_step_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (tmr_cnt == $past(tmr_cnt) || tmr_cnt == $past(tmr_cnt) + 1'b1));
endmodule

bind tmr_clk_src tmr_clk_src_chk #(.CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .sel_q      (sel_q),
    .am_q       (am_q),
    .inc_pulse  (inc_pulse),
    .tooth_pulse(tooth_pulse),
    .cfg_error  (cfg_error),
    .tmr_cnt    (tmr_cnt)
);

// File: tb/tb_tmr_clk_src.sv
module tb_tmr_clk_src;
    localparam int CNT_W   = 16;
    localparam int PRESC_W = 2;
    localparam int PAIRS   = 4;
    localparam int WIN     = 32 * PAIRS + 8;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               ext_pin = 1'b0;
    logic [2:0]         src_sel = 3'b001;
    logic               angle_mode = 1'b0;
    logic               inc_pulse, tooth_pulse, cfg_error;
    logic [PRESC_W-1:0] presc_cnt;
    logic [CNT_W-1:0]   tmr_cnt;

    int n_checks = 0;
    int n_fail   = 0;

    tmr_clk_src #(.PRESC_DIV(4), .CNT_W(CNT_W)) dut (
        .clk(clk), .rst_n(rst_n), .ext_pin(ext_pin), .src_sel(src_sel),
        .angle_mode(angle_mode), .inc_pulse(inc_pulse), .tooth_pulse(tooth_pulse),
        .cfg_error(cfg_error), .presc_cnt(presc_cnt), .tmr_cnt(tmr_cnt)
    );

    always #10 clk = ~clk;

    typedef struct packed {
        logic [2:0] sel;
        logic       am;
        logic [7:0] inc;
        logic [7:0] tooth;
        logic       err;
        logic [7:0] req;
    } vec_t;

    localparam vec_t VECS [14] = '{
        '{3'b000, 1'b0, 8'd8,  8'd0, 1'b0, 8'd1},  // R1 gated div8
        '{3'b001, 1'b0, 8'd4,  8'd0, 1'b0, 8'd2},  // R2 rising
        '{3'b010, 1'b0, 8'd4,  8'd0, 1'b0, 8'd3},  // R3 falling
        '{3'b011, 1'b0, 8'd8,  8'd0, 1'b0, 8'd4},  // R4 both edges
        '{3'b100, 1'b0, 8'd17, 8'd0, 1'b0, 8'd5},  // R5 free div8
        '{3'b111, 1'b0, 8'd0,  8'd0, 1'b0, 8'd6},  // R6 off
        '{3'b101, 1'b0, 8'd0,  8'd0, 1'b1, 8'd7},  // R7 reserved
        '{3'b110, 1'b0, 8'd0,  8'd0, 1'b1, 8'd7},  // R7 reserved
        '{3'b001, 1'b1, 8'd0,  8'd4, 1'b0, 8'd8},  // R8 tooth rising
        '{3'b010, 1'b1, 8'd0,  8'd4, 1'b0, 8'd8},  // R8 tooth falling
        '{3'b011, 1'b1, 8'd0,  8'd8, 1'b0, 8'd8},  // R8 tooth both
        '{3'b111, 1'b1, 8'd0,  8'd0, 1'b0, 8'd8},  // R8 angle off
        '{3'b000, 1'b1, 8'd0,  8'd0, 1'b1, 8'd9},  // R9 illegal
        '{3'b100, 1'b1, 8'd0,  8'd0, 1'b1, 8'd9}   // R9 illegal
    };

    task automatic check(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic do_reset(input logic [2:0] s, input logic am);
        @(negedge clk);
        rst_n = 1'b0; src_sel = s; angle_mode = am; ext_pin = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    // Drives PAIRS high/low pin pairs of 16 cycles each; counts pulses.
    task automatic run_window(output int n_inc, output int n_tooth);
        n_inc = 0; n_tooth = 0;
        for (int i = 0; i < WIN; i++) begin
            n_inc   += int'(inc_pulse);
            n_tooth += int'(tooth_pulse);
            ext_pin = ((i % 32) < 16) && (i < 32 * PAIRS);
            @(negedge clk);
        end
    endtask

    initial begin : watchdog
        #(20ns * 200000);
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin : main
        int ni, nt;
        // R12: reset state
        src_sel = 3'b100; angle_mode = 1'b0; ext_pin = 1'b1;
        repeat (4) @(negedge clk);
        check("R12 inc in reset", int'(inc_pulse), 0);
        check("R12 err in reset", int'(cfg_error), 0);
        check("R12 counters in reset", int'(presc_cnt) + int'(tmr_cnt), 0);

        // Vector table walk
        for (int v = 0; v < 14; v++) begin
            do_reset(VECS[v].sel, VECS[v].am);
            run_window(ni, nt);
            check($sformatf("R%0d inc sel=%b am=%b", VECS[v].req, VECS[v].sel, VECS[v].am),
                  ni, int'(VECS[v].inc));
            check($sformatf("R%0d tooth sel=%b am=%b", VECS[v].req, VECS[v].sel, VECS[v].am),
                  nt, int'(VECS[v].tooth));
            check($sformatf("R%0d err sel=%b am=%b", VECS[v].req, VECS[v].sel, VECS[v].am),
                  int'(cfg_error), int'(VECS[v].err));
        end

        // R10: latency and single-cycle width of an edge pulse
        do_reset(3'b001, 1'b0);
        ext_pin = 1'b1;            // sampled at next posedge P0
        @(negedge clk);
        check("R10 no pulse after P0", int'(inc_pulse), 0);
        @(negedge clk);
        check("R10 pulse after P1", int'(inc_pulse), 1);
        @(negedge clk);
        check("R10 pulse one cycle wide", int'(inc_pulse), 0);

        // R11: six rising edges -> prescaler 2, timer 1
        do_reset(3'b001, 1'b0);
        for (int k = 0; k < 6; k++) begin
            ext_pin = 1'b1; repeat (4) @(negedge clk);
            ext_pin = 1'b0; repeat (4) @(negedge clk);
        end
        check("R11 prescaler value", int'(presc_cnt), 2);
        check("R11 timer value", int'(tmr_cnt), 1);

        // R7: sticky after a legal selector, cleared by reset
        do_reset(3'b101, 1'b0);
        src_sel = 3'b001;
        repeat (4) @(negedge clk);
        check("R7 error sticky", int'(cfg_error), 1);
        ext_pin = 1'b1; repeat (4) @(negedge clk);
        check("R7 legal code resumes counting", int'(presc_cnt), 1);
        do_reset(3'b001, 1'b0);
        check("R7 error cleared by reset", int'(cfg_error), 0);

        // R1: gated mode with pin held low yields nothing
        do_reset(3'b000, 1'b0);
        ni = 0;
        for (int i = 0; i < 64; i++) begin
            ni += int'(inc_pulse);
            @(negedge clk);
        end
        check("R1 gated with low pin", ni, 0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule